// File: doc/BRIEF.md
# Triggered Scan List Sequencer

This block walks through a programmed list of conversion records on behalf of a sensing front end. Software sets up a control word: an operating mode, a trigger source, a trigger enable with an optional self-clear, a sample bit, a balance count and a record count. The sequencer then waits for the selected trigger. Each accepted trigger opens a balance (sample) window, issues a start pulse for the current record and waits for the converter's done strobe. Depending on the mode, one trigger runs either a single record or every record of the list back-to-back.

The mode also picks the interrupt policy. The choices are no interrupt, an interrupt per record, an interrupt at the end of the list, an interrupt per matching record, or a single end-of-list interrupt when any record in the pass matched. The comparator lives outside the block and reports a match together with each done strobe. When enabled, a DMA request pulse goes out as each record finishes, so that the next command can be loaded.

Top module: `scan_list_seq`

## Requirements
- R1: After reset `rec_idx_o` is 0, `trig_en_o` is 0, and `rec_start_o`, `sample_win_o`, `list_irq_o` and `dma_req_o` are all low.
- R2: A trigger is accepted only while `trig_en_o` is 1. A pulse on `trig_en_set_i` sets the enable and a pulse on `trig_en_clr_i` clears it. With `trig_autoclr_i` = 1, an accepted trigger clears the enable in the same edge. With it at 0, the enable stays set.
- R3: With `src_sel_i` = 0, the trigger is a 1-to-0 transition of `sample_i`. With `src_sel_i` = k (1..31), the trigger is `hw_trig_i[k-1]` and every other hardware line is ignored.
- R4: For a hardware trigger, `sample_win_o` stays high for `bal_cnt_i` cycles of `conv_tick_i` and `rec_start_o` pulses in the next cycle. With `bal_cnt_i` = 0, the start pulse comes in the cycle right after the accepting edge. With software source, `sample_win_o` follows `sample_i` while idle and the first record's start comes the cycle after the falling edge, with no counted window.
- R5: Modes 0, 1 and 2 run one record per trigger. `rec_idx_o` advances by one after each record and returns to 0 after record number `rec_cnt_i` (the list holds `rec_cnt_i`+1 records).
- R6: Modes 4 to 7 run every record from the current index to the last one on one trigger, each with its own balance window, and then return `rec_idx_o` to 0.
- R7: `list_irq_o` is a one-cycle pulse issued as a record completes. Modes 0 and 4 never pulse. Mode 1 pulses on every record. Modes 2 and 5 pulse only when the last record completes.
- R8: Mode 6 pulses for each record whose done strobe carries `match_i` = 1. Mode 7 pulses once when the last record completes, and only if any record of that pass matched. The any-match memory is cleared when a new pass begins.
- R9: Mode 3, or a `rec_cnt_i` of 32 or more, starts nothing. The trigger is not accepted and the enable is not self-cleared.
- R10: With `dma_en_i` = 1, `dma_req_o` pulses for one cycle as each record completes. With `dma_en_i` = 0, it stays low.
- R11: Triggers that arrive while a record or a back-to-back pass is in progress are ignored and start no extra record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Record/interrupt mode, 0..7 (3 reserved) |
| src_sel_i | input | 5 | Trigger source: 0 software, k selects hw_trig_i[k-1] |
| sample_i | input | 1 | Software sample bit |
| bal_cnt_i | input | 5 | Balance window length in conversion ticks |
| rec_cnt_i | input | 6 | Records in list minus one (32..63 reserved) |
| trig_autoclr_i | input | 1 | Clear the trigger enable when a trigger is accepted |
| trig_en_set_i | input | 1 | Pulse: set the trigger enable |
| trig_en_clr_i | input | 1 | Pulse: clear the trigger enable |
| dma_en_i | input | 1 | Allow per-record DMA requests |
| hw_trig_i | input | 31 | Hardware trigger lines |
| conv_tick_i | input | 1 | One pulse per conversion clock period |
| conv_done_i | input | 1 | Converter finished the current record |
| match_i | input | 1 | Comparator match, valid with conv_done_i |
| rec_start_o | output | 1 | One-cycle record start pulse |
| sample_win_o | output | 1 | Balance/sample window open |
| rec_idx_o | output | 5 | Current record index |
| list_irq_o | output | 1 | One-cycle list interrupt |
| dma_req_o | output | 1 | One-cycle DMA request |
| trig_en_o | output | 1 | Current trigger enable |

## Verification
The mode field is exercised with all-miss, single-match, two-match and repeated-pass match patterns. These separate the per-record policy from the end-of-list policy, and show whether the any-match flag leaks from one pass into the next. Hardware triggers are tried on the selected line, a non-selected line, with the enable clear, and in the middle of a burst. This tells the source decode, the enable gate and the busy lockout apart. Balance counts of 0 and 3, plus the software sample path, pin down where the start pulse falls relative to the window. Reserved mode and reserved count confirm that nothing starts.

// File: rtl/scan_list_pkg.sv
package scan_list_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BAL   = 2'd1,
    ST_START = 2'd2,
    ST_CONV  = 2'd3
  } seq_state_e;

  // Upper mode bit selects whole-list processing.
  function automatic logic mode_is_burst(input logic [2:0] m);
    return m[2];
  endfunction

  // Value 3 is the only mode that runs nothing.
  function automatic logic mode_runs(input logic [2:0] m);
    return m != 3'd3;
  endfunction

  // Interrupt decision at the completion of one record.
  function automatic logic irq_fire(input logic [2:0] m, input logic last,
                                    input logic hit, input logic any_hit);
    logic r;
    case (m)
      3'd1:    r = 1'b1;
      3'd2:    r = last;
      3'd5:    r = last;
      3'd6:    r = hit;
      3'd7:    r = last && (any_hit || hit);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/slq_trig_gate.sv
module slq_trig_gate #(
  parameter int NUM_HW_TRIG = 31,
  parameter int SRC_W       = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SRC_W-1:0]       src_sel_i,
  input  logic                   sample_i,
  input  logic [NUM_HW_TRIG-1:0] hw_trig_i,
  input  logic                   en_set_i,
  input  logic                   en_clr_i,
  input  logic                   autoclr_i,
  input  logic                   ready_i,
  output logic                   trig_en_o,
  output logic                   accept_o,
  output logic                   sw_src_o
);

  logic sample_q;
  logic trig_en_q;
  logic sw_fall;
  logic event_w;

  assign sw_src_o = (src_sel_i == '0);
  assign sw_fall  = sample_q && !sample_i;

  // Source decode: 0 is the software edge, k picks hardware line k-1.
  always_comb begin
    event_w = 1'b0;
    if (sw_src_o) begin
      event_w = sw_fall;
    end else begin
      for (int k = 1; k <= NUM_HW_TRIG; k++) begin
        if (src_sel_i == SRC_W'(k)) event_w = hw_trig_i[k-1];
      end
    end
  end

  assign accept_o  = trig_en_q && event_w && ready_i;
  assign trig_en_o = trig_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q  <= 1'b0;
      trig_en_q <= 1'b0;
    end else begin
      sample_q <= sample_i;
      if (en_clr_i || (accept_o && autoclr_i)) trig_en_q <= 1'b0;
      else if (en_set_i)                      trig_en_q <= 1'b1;
    end
  end

endmodule

// File: rtl/slq_bal_timer.sv
module slq_bal_timer #(
  parameter int BAL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BAL_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);

  logic [BAL_W-1:0] cnt_q;

  // Final tick of a running window.
  assign expire_o = tick_i && (cnt_q == BAL_W'(1)) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - BAL_W'(1);
  end

endmodule

// File: rtl/slq_event_out.sv
module slq_event_out
  import scan_list_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic       last_i,
  input  logic       match_i,
  input  logic [2:0] mode_i,
  input  logic       dma_en_i,
  input  logic       pass_start_i,
  output logic       irq_o,
  output logic       dma_o
);

  logic any_hit_q;
  logic irq_q;
  logic dma_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      any_hit_q <= 1'b0;
      irq_q     <= 1'b0;
      dma_q     <= 1'b0;
    end else begin
      irq_q <= done_i && irq_fire(mode_i, last_i, match_i, any_hit_q);
      dma_q <= done_i && dma_en_i;
      if (pass_start_i)          any_hit_q <= 1'b0;
      else if (done_i && match_i) any_hit_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;
  assign dma_o = dma_q;

endmodule

// File: rtl/scan_list_seq.sv
module scan_list_seq
  import scan_list_pkg::*;
#(
  parameter int NUM_HW_TRIG = 31,
  parameter int SRC_W       = 5,
  parameter int BAL_W       = 5,
  parameter int CNT_W       = 6,
  parameter int MAX_REC     = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             mode_i,
  input  logic [SRC_W-1:0]       src_sel_i,
  input  logic                   sample_i,
  input  logic [BAL_W-1:0]       bal_cnt_i,
  input  logic [CNT_W-1:0]       rec_cnt_i,
  input  logic                   trig_autoclr_i,
  input  logic                   trig_en_set_i,
  input  logic                   trig_en_clr_i,
  input  logic                   dma_en_i,
  input  logic [NUM_HW_TRIG-1:0] hw_trig_i,
  input  logic                   conv_tick_i,
  input  logic                   conv_done_i,
  input  logic                   match_i,
  output logic                   rec_start_o,
  output logic                   sample_win_o,
  output logic [$clog2(MAX_REC)-1:0] rec_idx_o,
  output logic                   list_irq_o,
  output logic                   dma_req_o,
  output logic                   trig_en_o
);

  localparam int IDX_W = $clog2(MAX_REC);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [2:0]       mode_q;
  logic             accept_w;
  logic             sw_src_w;
  logic             ready_w;
  logic             win_end_w;
  logic             tmr_load_w;
  logic             rec_done_w;
  logic             last_w;
  logic             pass_start_w;
  logic             busy_w;
  logic             cnt_ok_w;

  assign busy_w       = (state_q != ST_IDLE);
  assign cnt_ok_w     = (rec_cnt_i < CNT_W'(MAX_REC));
  assign ready_w      = !busy_w && mode_runs(mode_i) && cnt_ok_w;
  assign rec_done_w   = (state_q == ST_CONV) && conv_done_i;
  assign last_w       = (CNT_W'(idx_q) >= rec_cnt_i);
  assign pass_start_w = accept_w && (mode_is_burst(mode_i) || idx_q == '0);

  slq_trig_gate #(
    .NUM_HW_TRIG (NUM_HW_TRIG),
    .SRC_W       (SRC_W)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_sel_i (src_sel_i),
    .sample_i  (sample_i),
    .hw_trig_i (hw_trig_i),
    .en_set_i  (trig_en_set_i),
    .en_clr_i  (trig_en_clr_i),
    .autoclr_i (trig_autoclr_i),
    .ready_i   (ready_w),
    .trig_en_o (trig_en_o),
    .accept_o  (accept_w),
    .sw_src_o  (sw_src_w)
  );

  slq_bal_timer #(
    .BAL_W (BAL_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load_w),
    .load_val_i (bal_cnt_i),
    .tick_i     (conv_tick_i),
    .expire_o   (win_end_w)
  );

  slq_event_out u_events (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_i       (rec_done_w),
    .last_i       (last_w),
    .match_i      (match_i),
    .mode_i       (mode_q),
    .dma_en_i     (dma_en_i),
    .pass_start_i (pass_start_w),
    .irq_o        (list_irq_o),
    .dma_o        (dma_req_o)
  );

  // Sequencer next-state logic.
  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    tmr_load_w = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept_w) begin
          if (sw_src_w || bal_cnt_i == '0) begin
            state_d = ST_START;
          end else begin
            state_d    = ST_BAL;
            tmr_load_w = 1'b1;
          end
        end
      end
      ST_BAL: begin
        if (win_end_w) state_d = ST_START;
      end
      ST_START: state_d = ST_CONV;
      ST_CONV: begin
        if (conv_done_i) begin
          idx_d = last_w ? '0 : idx_q + IDX_W'(1);
          if (mode_is_burst(mode_q) && !last_w) begin
            if (bal_cnt_i == '0) begin
              state_d = ST_START;
            end else begin
              state_d    = ST_BAL;
              tmr_load_w = 1'b1;
            end
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (accept_w) mode_q <= mode_i;
    end
  end

  assign rec_start_o  = (state_q == ST_START);
  assign sample_win_o = (state_q == ST_BAL) ||
                        (state_q == ST_IDLE && sw_src_w && sample_i);
  assign rec_idx_o    = idx_q;

endmodule

// File: rtl/slq_checker.sv
module slq_checker #(
  parameter int CNT_W   = 6,
  parameter int MAX_REC = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             accept_w,
  input logic             busy_w,
  input logic             win_end_w,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] rec_cnt_i,
  input logic             trig_autoclr_i,
  input logic             trig_en_o,
  input logic             rec_start_o,
  input logic             sample_win_o,
  input logic             list_irq_o,
  input logic             dma_req_o,
  input logic             dma_en_i
);

  a_r2_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |-> trig_en_o);

  a_r2_autoclear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_w && trig_autoclr_i) |=> !trig_en_o);

  a_r4_start_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_w |=> rec_start_o);

  a_r4_start_outside_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_start_o |-> !sample_win_o);

  a_r7_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    list_irq_o |=> !list_irq_o);

  a_r9_reserved_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |-> (mode_i != 3'd3 && rec_cnt_i < CNT_W'(MAX_REC)));

  a_r10_dma_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> $past(dma_en_i));

  a_r11_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_w |-> !accept_w);

endmodule

bind scan_list_seq slq_checker #(
  .CNT_W   (CNT_W),
  .MAX_REC (MAX_REC)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .accept_w       (accept_w),
  .busy_w         (busy_w),
  .win_end_w      (win_end_w),
  .mode_i         (mode_i),
  .rec_cnt_i      (rec_cnt_i),
  .trig_autoclr_i (trig_autoclr_i),
  .trig_en_o      (trig_en_o),
  .rec_start_o    (rec_start_o),
  .sample_win_o   (sample_win_o),
  .list_irq_o     (list_irq_o),
  .dma_req_o      (dma_req_o),
  .dma_en_i       (dma_en_i)
);

// File: tb/scan_list_seq_tb_top.sv
`timescale 1ns/1ps
module scan_list_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [4:0]  src = '0;
  logic        sample = 1'b0;
  logic [4:0]  bal = '0;
  logic [5:0]  rcnt = '0;
  logic        autoclr = 1'b0;
  logic        en_set = 1'b0;
  logic        en_clr = 1'b0;
  logic        dma_en = 1'b0;
  logic [30:0] hw = '0;
  logic        tick = 1'b1;
  logic        done = 1'b0;
  logic        match = 1'b0;
  logic        rec_start, win, irq, dma, trig_en;
  logic [4:0]  idx;

  int total = 0;
  int bad   = 0;
  int n_start = 0, n_win = 0, n_irq = 0, n_dma = 0;
  int s0, w0, i0, d0;

  always #5 clk = ~clk;

  scan_list_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .src_sel_i(src),
    .sample_i(sample), .bal_cnt_i(bal), .rec_cnt_i(rcnt),
    .trig_autoclr_i(autoclr), .trig_en_set_i(en_set), .trig_en_clr_i(en_clr),
    .dma_en_i(dma_en), .hw_trig_i(hw), .conv_tick_i(tick),
    .conv_done_i(done), .match_i(match), .rec_start_o(rec_start),
    .sample_win_o(win), .rec_idx_o(idx), .list_irq_o(irq),
    .dma_req_o(dma), .trig_en_o(trig_en)
  );

  // Pulse counters, sampled shortly after each rising edge.
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (rec_start) n_start++;
      if (win)       n_win++;
      if (irq)       n_irq++;
      if (dma)       n_dma++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic snap();
    s0 = n_start; w0 = n_win; i0 = n_irq; d0 = n_dma;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hw = '0; done = 1'b0; match = 1'b0; sample = 1'b0;
    en_set = 1'b0; en_clr = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int m, input int s, input int b, input int c,
                     input bit ac, input bit de);
    mode = 3'(m); src = 5'(s); bal = 5'(b); rcnt = 6'(c);
    autoclr = ac; dma_en = de;
  endtask

  task automatic enable();
    en_set = 1'b1;
    @(negedge clk);
    en_set = 1'b0;
  endtask

  task automatic fire_hw(input int bitn);
    hw[bitn] = 1'b1;
    @(negedge clk);
    hw = '0;
  endtask

  // Answers n records with done strobes; pat bit i is record i's match.
  task automatic serve(input int n, input logic [7:0] pat, input int poke);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      while (!rec_start && w < 200) begin
        @(negedge clk);
        w++;
      end
      if (!rec_start) begin
        chk("R5/R6 record start seen", 0, 1);
        return;
      end
      @(negedge clk);
      done = 1'b1; match = pat[i];
      if (poke >= 0 && i == 0) hw[poke] = 1'b1;
      @(negedge clk);
      done = 1'b0; match = 1'b0; hw = '0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 idx", int'(idx), 0);
    chk("R1 trig_en", int'(trig_en), 0);
    chk("R1 outputs", int'({rec_start, win, irq, dma}), 0);
  endtask

  task automatic t_gate();
    do_reset();
    cfg(1, 5, 0, 3, 1'b0, 1'b0);
    snap();
    fire_hw(4);
    repeat (10) @(negedge clk);
    chk("R2 no start while disabled", n_start - s0, 0);
    enable();
    fire_hw(5);
    fire_hw(0);
    repeat (10) @(negedge clk);
    chk("R3 other lines ignored", n_start - s0, 0);
    chk("R2 enable kept", int'(trig_en), 1);
  endtask

  task automatic t_single_irq_dma();
    do_reset();
    cfg(1, 5, 3, 3, 1'b1, 1'b1);
    enable();
    snap();
    fire_hw(4);
    chk("R2 autoclear", int'(trig_en), 0);
    serve(1, 8'h00, -1);
    chk("R4 window length", n_win - w0, 3);
    chk("R5 one record", n_start - s0, 1);
    chk("R7 mode1 irq", n_irq - i0, 1);
    chk("R10 dma on", n_dma - d0, 1);
    chk("R5 idx advance", int'(idx), 1);
    fire_hw(4);
    repeat (10) @(negedge clk);
    chk("R2 cleared enable blocks", n_start - s0, 1);
  endtask

  task automatic t_wrap_mode0();
    do_reset();
    cfg(0, 5, 0, 2, 1'b0, 1'b0);
    enable();
    snap();
    fire_hw(4); serve(1, 8'h00, -1);
    chk("R5 idx 1", int'(idx), 1);
    fire_hw(4); serve(1, 8'h00, -1);
    chk("R5 idx 2", int'(idx), 2);
    fire_hw(4); serve(1, 8'h00, -1);
    chk("R5 idx wrap", int'(idx), 0);
    chk("R7 mode0 silent", n_irq - i0, 0);
    chk("R10 dma off", n_dma - d0, 0);
  endtask

  task automatic t_mode2();
    do_reset();
    cfg(2, 5, 0, 1, 1'b0, 1'b0);
    enable();
    snap();
    fire_hw(4); serve(1, 8'h00, -1);
    chk("R7 mode2 not first", n_irq - i0, 0);
    fire_hw(4); serve(1, 8'h00, -1);
    chk("R7 mode2 last", n_irq - i0, 1);
  endtask

  task automatic t_burst5();
    do_reset();
    cfg(5, 5, 2, 3, 1'b0, 1'b1);
    enable();
    snap();
    fire_hw(4);
    serve(4, 8'h00, 4);
    repeat (20) @(negedge clk);
    chk("R6 all records", n_start - s0, 4);
    chk("R11 busy trigger ignored", n_start - s0, 4);
    chk("R7 mode5 once", n_irq - i0, 1);
    chk("R10 dma per record", n_dma - d0, 4);
    chk("R6 idx back to 0", int'(idx), 0);
    chk("R4 windows per record", n_win - w0, 8);
  endtask

  task automatic t_mode4();
    do_reset();
    cfg(4, 5, 0, 3, 1'b0, 1'b0);
    enable();
    snap();
    fire_hw(4);
    serve(4, 8'hff, -1);
    chk("R6 mode4 records", n_start - s0, 4);
    chk("R7 mode4 silent", n_irq - i0, 0);
  endtask

  task automatic t_mode6();
    do_reset();
    cfg(6, 5, 0, 3, 1'b0, 1'b0);
    enable();
    snap();
    fire_hw(4);
    serve(4, 8'b0110, -1);
    chk("R8 mode6 per match", n_irq - i0, 2);
  endtask

  task automatic t_mode7();
    do_reset();
    cfg(7, 5, 0, 3, 1'b0, 1'b0);
    enable();
    snap();
    fire_hw(4); serve(4, 8'b0000, -1);
    chk("R8 mode7 no match", n_irq - i0, 0);
    fire_hw(4); serve(4, 8'b0010, -1);
    chk("R8 mode7 any match", n_irq - i0, 1);
    fire_hw(4); serve(4, 8'b0000, -1);
    chk("R8 mode7 flag cleared per pass", n_irq - i0, 1);
  endtask

  task automatic t_reserved();
    do_reset();
    cfg(3, 5, 0, 3, 1'b1, 1'b0);
    enable();
    snap();
    fire_hw(4);
    repeat (10) @(negedge clk);
    chk("R9 mode3 no start", n_start - s0, 0);
    chk("R9 mode3 enable kept", int'(trig_en), 1);
    cfg(1, 5, 0, 40, 1'b1, 1'b0);
    fire_hw(4);
    repeat (10) @(negedge clk);
    chk("R9 count 40 no start", n_start - s0, 0);
  endtask

  task automatic t_software();
    do_reset();
    cfg(1, 0, 7, 0, 1'b0, 1'b0);
    enable();
    sample = 1'b1;
    @(negedge clk);
    chk("R4 sw window held", int'(win), 1);
    chk("R3 sw high no start", int'(rec_start), 0);
    snap();
    sample = 1'b0;
    @(negedge clk);
    chk("R3 sw fall starts", int'(rec_start), 1);
    serve(1, 8'h00, -1);
    chk("R4 sw no counted window", n_win - w0, 0);
    chk("R3 sw one record", n_start - s0, 1);
  endtask

  task automatic t_bal_zero();
    do_reset();
    cfg(1, 5, 0, 3, 1'b0, 1'b0);
    enable();
    snap();
    hw[4] = 1'b1;
    @(negedge clk);
    hw = '0;
    chk("R4 bal0 start next cycle", int'(rec_start), 1);
    serve(1, 8'h00, -1);
    chk("R4 bal0 no window", n_win - w0, 0);
  endtask

  initial begin
    t_reset();
    t_gate();
    t_single_irq_dma();
    t_wrap_mode0();
    t_mode2();
    t_burst5();
    t_mode4();
    t_mode6();
    t_mode7();
    t_reserved();
    t_software();
    t_bal_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule